// File: doc/BRIEF.md
# Queued Command Active-Tag Register

This block holds a 32-entry bit vector that records which queued-command tags are still outstanding on a serial storage link. Each bit stands for one tag. Software marks a tag as issued by writing a 1 to its bit. Software can also wipe the whole vector by writing an all-zero word. It cannot drop single tags. Only the link can do that.

On the link side, each received Set Device Bits frame is reported with a one-cycle strobe and the frame's second data word. Every tag whose bit is 1 in that word is retired. The same strobe also latches a sticky arrival flag. The flag sits in a separate status word, and software acknowledges it by writing 1 to bit 0 of that word. A single combinational read port returns whichever word is selected.

Top module: `qtag_active_reg`

## Requirements
- R1: After a synchronous active-high reset, the tag vector and the arrival flag are both zero.
- R2: A write to the tag word (wr_addr = 0) with nonzero data sets, on the next clock edge, every tag bit where the data has a 1.
- R3: A write of exactly zero to the tag word clears all tag bits on the next edge.
- R4: A nonzero write to the tag word never clears any bit. Bits where the data is 0 keep their value.
- R5: When sdb_valid is high, every tag bit that is 1 in sdb_dword is 0 after the edge. Bits that are 0 in sdb_dword are not affected by the frame.
- R6: If a software set and a frame clear hit the same bit in the same cycle, the bit ends up 0.
- R7: sdb_valid high at an edge leaves the arrival flag at 1 after that edge.
- R8: The arrival flag stays at 1 until a write to the status word (wr_addr = 1) with bit 0 = 1. A status write with bit 0 = 0 leaves the flag unchanged.
- R9: A flag acknowledge in the same cycle as a new frame arrival leaves the flag at 1.
- R10: Writes to the status word never change the tag vector. rd_data returns the tag vector when rd_addr = 0. When rd_addr = 1 it returns the flag in bit 0 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 1 | Write target: 0 = tag word, 1 = status word |
| wr_data | input | TAG_W | Software write data |
| rd_addr | input | 1 | Read select: 0 = tag word, 1 = status word |
| rd_data | output | TAG_W | Selected register contents |
| sdb_valid | input | 1 | One-cycle strobe for a received Set Device Bits frame |
| sdb_dword | input | TAG_W | Second data word of that frame (tags to retire) |
| active_tags | output | TAG_W | Current outstanding-tag vector |
| sdb_seen | output | 1 | Sticky frame-arrival flag |

## Verification
Set-only writes are tried with masks that overlap the bits already held and with masks that do not. This shows OR-accumulation apart from overwrite, and it shows that no write ever clears a bit. A zero write is applied to a fully populated vector, which tells the bulk clear apart from an ignored write. Frames carrying sparse, partial retire masks show that only the named tags drop. Two same-cycle collisions are driven: a set against a retire on the same bit, and a flag acknowledge against a new arrival. These expose the priority order, which ordinary sequences never reveal.

// File: rtl/qtag_pkg.sv
package qtag_pkg;

    localparam int QT_TAGS = 32;

    typedef enum logic {
        QT_SEL_TAGS = 1'b0,
        QT_SEL_STAT = 1'b1
    } qt_sel_e;

    typedef struct packed {
        logic set_en;
        logic bulk_clr;
        logic ack_flag;
    } qt_sw_cmd_t;

    typedef struct packed {
        logic retire_en;
        logic arrive;
    } qt_link_evt_t;

    function automatic logic qt_is_zero(input logic [QT_TAGS-1:0] v, input int w);
        logic z;
        z = 1'b1;
        for (int i = 0; i < QT_TAGS; i++) begin
            if (i < w && v[i]) z = 1'b0;
        end
        return z;
    endfunction

endpackage

// File: rtl/qtag_sw_decode.sv
module qtag_sw_decode
    import qtag_pkg::*;
#(
    parameter int TAG_W = QT_TAGS
) (
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [TAG_W-1:0] wr_data,
    output qt_sw_cmd_t       cmd,
    output logic [TAG_W-1:0] set_mask
);
    qt_sel_e sel;
    logic    data_zero;

    always_comb begin
        sel       = qt_sel_e'(wr_addr);
        data_zero = (wr_data == '0);
        cmd       = '0;
        set_mask  = '0;
        if (wr_en) begin
            unique case (sel)
                QT_SEL_TAGS: begin
                    cmd.bulk_clr = data_zero;
                    cmd.set_en   = !data_zero;
                    set_mask     = wr_data;
                end
                QT_SEL_STAT: begin
                    cmd.ack_flag = wr_data[0];
                end
                default: cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/qtag_vec.sv
module qtag_vec
    import qtag_pkg::*;
#(
    parameter int TAG_W = QT_TAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  qt_sw_cmd_t       cmd,
    input  logic [TAG_W-1:0] set_mask,
    input  qt_link_evt_t     evt,
    input  logic [TAG_W-1:0] retire_mask,
    output logic [TAG_W-1:0] tags_q
);
    // One slice per tag: bulk clear, then set, then retire (retire has the last word).
    for (genvar g = 0; g < TAG_W; g++) begin : g_tag
        logic nxt;
        always_comb begin
            nxt = tags_q[g];
            if (cmd.bulk_clr) nxt = 1'b0;
            if (cmd.set_en && set_mask[g]) nxt = 1'b1;
            if (evt.retire_en && retire_mask[g]) nxt = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst) tags_q[g] <= 1'b0;
            else     tags_q[g] <= nxt;
        end
    end
endmodule

// File: rtl/qtag_seen_flag.sv
module qtag_seen_flag
    import qtag_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  qt_sw_cmd_t   cmd,
    input  qt_link_evt_t evt,
    output logic         seen_q
);
    always_ff @(posedge clk) begin
        if (rst)               seen_q <= 1'b0;
        else if (evt.arrive)   seen_q <= 1'b1;
        else if (cmd.ack_flag) seen_q <= 1'b0;
    end
endmodule

// File: rtl/qtag_rd_mux.sv
module qtag_rd_mux
    import qtag_pkg::*;
#(
    parameter int TAG_W = QT_TAGS
) (
    input  logic             rd_addr,
    input  logic [TAG_W-1:0] tags,
    input  logic             seen,
    output logic [TAG_W-1:0] rd_data
);
    logic [TAG_W-1:0] stat_word;

    always_comb begin
        stat_word    = '0;
        stat_word[0] = seen;
        unique case (qt_sel_e'(rd_addr))
            QT_SEL_TAGS: rd_data = tags;
            QT_SEL_STAT: rd_data = stat_word;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/qtag_active_reg.sv
module qtag_active_reg
    import qtag_pkg::*;
#(
    parameter int TAG_W = QT_TAGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [TAG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [TAG_W-1:0] rd_data,
    input  logic             sdb_valid,
    input  logic [TAG_W-1:0] sdb_dword,
    output logic [TAG_W-1:0] active_tags,
    output logic             sdb_seen
);
    qt_sw_cmd_t       sw_cmd;
    logic [TAG_W-1:0] sw_set_mask;
    qt_link_evt_t     link_evt;

    always_comb begin
        link_evt.retire_en = sdb_valid;
        link_evt.arrive    = sdb_valid;
    end

    qtag_sw_decode #(.TAG_W(TAG_W)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cmd      (sw_cmd),
        .set_mask (sw_set_mask)
    );

    qtag_vec #(.TAG_W(TAG_W)) u_vec (
        .clk         (clk),
        .rst         (rst),
        .cmd         (sw_cmd),
        .set_mask    (sw_set_mask),
        .evt         (link_evt),
        .retire_mask (sdb_dword),
        .tags_q      (active_tags)
    );

    qtag_seen_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .cmd    (sw_cmd),
        .evt    (link_evt),
        .seen_q (sdb_seen)
    );

    qtag_rd_mux #(.TAG_W(TAG_W)) u_rd (
        .rd_addr (rd_addr),
        .tags    (active_tags),
        .seen    (sdb_seen),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/qtag_active_reg_chk.sv
module qtag_active_reg_chk #(
    parameter int TAG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [TAG_W-1:0] wr_data,
    input logic             sdb_valid,
    input logic [TAG_W-1:0] sdb_dword,
    input logic [TAG_W-1:0] active_tags,
    input logic             sdb_seen
);
    logic [TAG_W-1:0] retire_now;
    assign retire_now = sdb_valid ? sdb_dword : '0;

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (active_tags == '0) && !sdb_seen);

    // R2
    a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && wr_data != '0 && !sdb_valid)
        |=> ((active_tags & $past(wr_data)) == $past(wr_data)));

    // R3
    a_r3_bulk_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && wr_data == '0) |=> (active_tags == '0));

    // R4
    a_r4_no_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && !wr_addr && wr_data == '0))
        |=> ((active_tags & $past(active_tags & ~retire_now))
             == $past(active_tags & ~retire_now)));

    // R5, R6
    a_r5_retire: assert property (@(posedge clk) disable iff (rst)
        sdb_valid |=> ((active_tags & $past(sdb_dword)) == '0));

    // R7
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
        sdb_valid |=> sdb_seen);

    // R8
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (sdb_seen && !(wr_en && wr_addr && wr_data[0])) |=> sdb_seen);

    // R10
    a_r10_stat_write_keeps_tags: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr && !sdb_valid) |=> $stable(active_tags));
endmodule

bind qtag_active_reg qtag_active_reg_chk #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sdb_valid   (sdb_valid),
    .sdb_dword   (sdb_dword),
    .active_tags (active_tags),
    .sdb_seen    (sdb_seen)
);

// File: tb/qtag_active_reg_tb.sv
module qtag_active_reg_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic         wr_addr;
    logic [W-1:0] wr_data;
    logic         rd_addr;
    logic [W-1:0] rd_data;
    logic         sdb_valid;
    logic [W-1:0] sdb_dword;
    logic [W-1:0] active_tags;
    logic         sdb_seen;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    qtag_active_reg #(.TAG_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .sdb_valid   (sdb_valid),
        .sdb_dword   (sdb_dword),
        .active_tags (active_tags),
        .sdb_seen    (sdb_seen)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle of stimulus; returns at the following falling edge.
    task automatic cycle(input logic we, input logic wa, input logic [W-1:0] wd,
                         input logic sv, input logic [W-1:0] sd);
        wr_en = we; wr_addr = wa; wr_data = wd; sdb_valid = sv; sdb_dword = sd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; sdb_valid = 1'b0; wr_data = '0; sdb_dword = '0;
    endtask

    task automatic check_read(input string req, input logic [W-1:0] exp_tags, input logic exp_flag);
        rd_addr = 1'b0; #1;
        check(req, rd_data, exp_tags);
        rd_addr = 1'b1; #1;
        check(req, rd_data, {{(W-1){1'b0}}, exp_flag});
        rd_addr = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        cycle(1'b0, 1'b0, '0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0, 1'b0, '0);
        rst = 1'b0;
        check("R1 tags", active_tags, '0);
        check("R1 flag", {31'b0, sdb_seen}, '0);
        check_read("R1 R10 read", '0, 1'b0);
    endtask

    task automatic t_set_only;
        cycle(1'b1, 1'b0, 32'h0000_00A5, 1'b0, '0);
        check("R2 first set", active_tags, 32'h0000_00A5);
        cycle(1'b1, 1'b0, 32'h0000_0F0F, 1'b0, '0);
        check("R2 R4 overlap set", active_tags, 32'h0000_0FAF);
        cycle(1'b1, 1'b0, 32'h8000_0000, 1'b0, '0);
        check("R4 disjoint set keeps bits", active_tags, 32'h8000_0FAF);
    endtask

    task automatic t_status_write;
        cycle(1'b1, 1'b1, 32'hFFFF_FFFE, 1'b0, '0);
        check("R10 status write keeps tags", active_tags, 32'h8000_0FAF);
        check("R8 ack bit0=0 no flag", {31'b0, sdb_seen}, '0);
        check_read("R10 read", 32'h8000_0FAF, 1'b0);
    endtask

    task automatic t_bulk;
        cycle(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, '0);
        check("R2 all set", active_tags, 32'hFFFF_FFFF);
        cycle(1'b1, 1'b0, 32'h0000_0000, 1'b0, '0);
        check("R3 bulk clear", active_tags, '0);
    endtask

    task automatic t_retire;
        cycle(1'b1, 1'b0, 32'hFFFF_00FF, 1'b0, '0);
        cycle(1'b0, 1'b0, '0, 1'b1, 32'h0F0F_000F);
        check("R5 partial retire", active_tags, 32'hF0F0_00F0);
        check("R7 flag set", {31'b0, sdb_seen}, 32'h1);
        check_read("R10 read after frame", 32'hF0F0_00F0, 1'b1);
    endtask

    task automatic t_flag_ack;
        cycle(1'b1, 1'b1, 32'h0000_0000, 1'b0, '0);
        check("R8 ack bit0=0 keeps flag", {31'b0, sdb_seen}, 32'h1);
        cycle(1'b0, 1'b0, '0, 1'b0, '0);
        check("R8 idle keeps flag", {31'b0, sdb_seen}, 32'h1);
        cycle(1'b1, 1'b1, 32'h0000_0001, 1'b0, '0);
        check("R8 ack clears flag", {31'b0, sdb_seen}, '0);
        check("R10 ack keeps tags", active_tags, 32'hF0F0_00F0);
    endtask

    task automatic t_conflict;
        // set bits 0,1 while frame retires bits 0 and 4
        cycle(1'b1, 1'b0, 32'h0000_0003, 1'b1, 32'h0000_0011);
        check("R6 retire beats set", active_tags, 32'hF0F0_00E2);
        // bulk clear together with frame
        cycle(1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h0000_0100);
        check("R3 bulk with frame", active_tags, '0);
    endtask

    task automatic t_flag_race;
        check("R7 flag before race", {31'b0, sdb_seen}, 32'h1);
        cycle(1'b1, 1'b1, 32'h0000_0001, 1'b1, 32'h0000_0000);
        check("R9 arrival beats ack", {31'b0, sdb_seen}, 32'h1);
        cycle(1'b1, 1'b1, 32'h0000_0001, 1'b0, '0);
        check("R8 later ack clears", {31'b0, sdb_seen}, '0);
    endtask

    initial begin
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0;
        sdb_valid = 1'b0; sdb_dword = '0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_only();
        t_status_write();
        t_bulk();
        t_retire();
        t_flag_ack();
        t_conflict();
        t_flag_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule